// File: doc/BRIEF.md
# March Algorithm Memory Self-Test Sequencer

This block is a self-test engine for a single-port word RAM of `WORDS` entries with a one-cycle read latency. A start pulse launches one of three built-in march algorithms. An algorithm is a series of elements. Each element sweeps the address space either upward or downward. At each address it applies a short ordered list of operations before it moves on. An operation either writes a solid word of zeros or ones, or reads the word and compares it with a solid expected value.

The engine issues one RAM operation per clock. It lines each comparison up with the data that returns one cycle after the read. It keeps the location of the first mismatch and raises a sticky fail flag. It then either keeps running to the end or halts, as set at start. Completion is a single-cycle done pulse.

Top module: `march_bist`

## Requirements
- R1: After reset, busy, done and fail are low and neither mem_we nor mem_re is asserted.
- R2: A start pulse samples alg_sel and stop_on_fail and clears fail. The first operation appears in the cycle after the start edge, at address 0. A start during a run abandons that run and restarts from the first element.
- R3: Exactly one operation is issued per busy cycle, and mem_we and mem_re are never high together. All operations of an element are applied to one address before the address moves. A write drives every data bit to the operation's value (0 gives all zeros, 1 gives all ones).
- R4: alg_sel = 0 runs 5·WORDS operations: up(w0); up(r0,w1); down(r1,w0). alg_sel = 3 runs this same sequence.
- R5: alg_sel = 1 runs 6·WORDS operations: up(w0); up(r0,w1); down(r1,w0,r0).
- R6: alg_sel = 2 runs 10·WORDS operations: up(w0); up(r0,w1); up(r1,w0); down(r0,w1); down(r1,w0); up(r0).
- R7: Up sweeps run 0 to WORDS−1 and down sweeps run WORDS−1 to 0. The initialising write element and the final order-free read element both use the upward order. mem_addr never exceeds WORDS−1 while an operation is issued.
- R8: A read is compared in the following cycle. Any differing bit makes fail rise one cycle later. fail then stays high until the next start.
- R9: On the first mismatch, fail_addr, fail_elem (element number from 0) and fail_op (position within the element from 0) record the failing read. Later mismatches leave them unchanged.
- R10: With stop_on_fail = 1, the edge after the failing compare ends the run: busy falls and done pulses. The only operation issued after the failing read is the one already issued in its compare cycle. With stop_on_fail = 0 the algorithm runs to its end.
- R11: When the run is not halted early, one cycle with busy high and no RAM operation follows the last operation. The next cycle has done high for exactly one cycle with busy low, and fail already includes the final read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch or relaunch the selected algorithm |
| alg_sel | input | 2 | Algorithm code (0, 1, 2; 3 behaves as 0) |
| stop_on_fail | input | 1 | Halt at the first mismatch when high |
| mem_addr | output | $clog2(WORDS) | RAM word address |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe; data expected next cycle |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data, one cycle after mem_re |
| busy | output | 1 | Algorithm in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | $clog2(WORDS) | Address of first mismatch |
| fail_elem | output | 3 | Element number of first mismatch |
| fail_op | output | 2 | Operation position of first mismatch |

## Verification
The collision of interest is the last compare of a run landing on the same edge that produces done. The fail flag and the capture registers must update on that edge while the run closes. The bench sets this up with a cell at address 0 that cannot fall from 1 to 0, running the 6·WORDS algorithm with halting enabled. The only mismatch is then the very last read. The reference model expects fail and done to rise in the same cycle, with the capture naming element 2, position 2, address 0. A second overlap is a halt requested while a write is already on the bus; the model requires that write to appear and nothing after it.

// File: rtl/march_bist.sv
module march_bist #(
  parameter int WORDS = 12,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [1:0]               alg_sel,
  input  logic                     stop_on_fail,
  output logic [$clog2(WORDS)-1:0] mem_addr,
  output logic                     mem_we,
  output logic                     mem_re,
  output logic [DW-1:0]            mem_wdata,
  input  logic [DW-1:0]            mem_rdata,
  output logic                     busy,
  output logic                     done,
  output logic                     fail,
  output logic [$clog2(WORDS)-1:0] fail_addr,
  output logic [2:0]               fail_elem,
  output logic [1:0]               fail_op
);
  localparam int AW = $clog2(WORDS);
  localparam logic [AW-1:0] TOP = AW'(WORDS - 1);
  localparam logic [1:0] R0 = 2'b00, R1 = 2'b01, W0 = 2'b10, W1 = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  // descriptor: {last, down, count[1:0], third, second, first}
  function automatic logic [9:0] edesc(input logic [1:0] a, input logic [2:0] e);
    logic [1:0] s;
    s = (a == 2'd3) ? 2'd0 : a;
    edesc = '0;
    if (e == 3'd0)      edesc = {1'b0, 1'b0, 2'd1, R0, R0, W0};
    else if (e == 3'd1) edesc = {1'b0, 1'b0, 2'd2, R0, W1, R0};
    else begin
      case (s)
        2'd0:    edesc = {1'b1, 1'b1, 2'd2, R0, W0, R1};
        2'd1:    edesc = {1'b1, 1'b1, 2'd3, R0, W0, R1};
        default: begin
          case (e)
            3'd2:    edesc = {1'b0, 1'b0, 2'd2, R0, W0, R1};
            3'd3:    edesc = {1'b0, 1'b1, 2'd2, R0, W1, R0};
            3'd4:    edesc = {1'b0, 1'b1, 2'd2, R0, W0, R1};
            default: edesc = {1'b1, 1'b0, 2'd1, R0, R0, R0};
          endcase
        end
      endcase
    end
  endfunction

  st_t           st;
  logic [1:0]    alg_q, op_q;
  logic [2:0]    elem_q;
  logic [AW-1:0] addr_q;
  logic          sof_q;
  logic          chk_v, chk_exp;
  logic [AW-1:0] chk_addr;
  logic [2:0]    chk_elem;
  logic [1:0]    chk_op;
  logic [9:0]    cur, nxt;
  logic [1:0]    op;
  logic          run, down, at_end, op_end, mismatch;

  assign cur    = edesc(alg_q, elem_q);
  assign nxt    = edesc(alg_q, elem_q + 3'd1);
  assign down   = cur[8];
  assign op     = (op_q == 2'd0) ? cur[1:0] : (op_q == 2'd1) ? cur[3:2] : cur[5:4];
  assign run    = (st == S_RUN);
  assign at_end = down ? (addr_q == '0) : (addr_q == TOP);
  assign op_end = (op_q == cur[7:6] - 2'd1);

  assign mem_we    = run & op[1];
  assign mem_re    = run & ~op[1];
  assign mem_addr  = addr_q;
  assign mem_wdata = mem_we ? {DW{op[0]}} : '0;
  assign busy      = (st != S_IDLE);
  assign mismatch  = chk_v && (mem_rdata != {DW{chk_exp}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; alg_q <= '0; op_q <= '0; elem_q <= '0; addr_q <= '0; sof_q <= 1'b0;
      chk_v <= 1'b0; chk_exp <= 1'b0; chk_addr <= '0; chk_elem <= '0; chk_op <= '0;
      done <= 1'b0; fail <= 1'b0; fail_addr <= '0; fail_elem <= '0; fail_op <= '0;
    end else begin
      done     <= 1'b0;
      chk_v    <= mem_re;
      chk_exp  <= op[0];
      chk_addr <= addr_q;
      chk_elem <= elem_q;
      chk_op   <= op_q;
      if (mismatch && !fail) begin
        fail <= 1'b1; fail_addr <= chk_addr; fail_elem <= chk_elem; fail_op <= chk_op;
      end
      if (start) begin
        st <= S_RUN; alg_q <= alg_sel; sof_q <= stop_on_fail;
        elem_q <= '0; op_q <= '0; addr_q <= '0; fail <= 1'b0; chk_v <= 1'b0;
      end else if (mismatch && sof_q) begin
        st <= S_IDLE; done <= 1'b1; chk_v <= 1'b0;
      end else if (st == S_FIN) begin
        st <= S_IDLE; done <= 1'b1;
      end else if (run) begin
        if (!op_end) op_q <= op_q + 2'd1;
        else begin
          op_q <= '0;
          if (!at_end) addr_q <= down ? addr_q - 1'b1 : addr_q + 1'b1;
          else if (cur[9]) st <= S_FIN;
          else begin
            elem_q <= elem_q + 3'd1;
            addr_q <= nxt[8] ? TOP : '0;
          end
        end
      end
    end
  end

  a_r3_single_access: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re));
  a_r7_addr_range: assert property (@(posedge clk) disable iff (!rst_n) (mem_we || mem_re) |-> mem_addr <= TOP);
  a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy && !done && !fail);
  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n) fail && !start |=> fail);
  a_r9_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !start |=> $stable(fail_addr) && $stable(fail_elem) && $stable(fail_op));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && !mem_we && !mem_re);
endmodule

// File: tb/march_bist_bench.sv
`timescale 1ns/1ps
module march_bist_bench;
  localparam int WORDS = 12;
  localparam int DW    = 8;
  localparam int AW    = $clog2(WORDS);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop_on_fail = 1'b0;
  logic [1:0] alg_sel = '0;
  logic [AW-1:0] mem_addr, fail_addr;
  logic mem_we, mem_re, busy, done, fail;
  logic [DW-1:0] mem_wdata, rdata = '0;
  logic [2:0] fail_elem;
  logic [1:0] fail_op;

  always #2 clk = ~clk;

  march_bist #(.WORDS(WORDS), .DW(DW)) u_march_bist (
    .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel), .stop_on_fail(stop_on_fail),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(rdata), .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
    .fail_elem(fail_elem), .fail_op(fail_op));

  int total = 0, bad = 0;
  int fmode = 0, fa = 0, fb = 0;
  logic [DW-1:0] ram [WORDS];
  logic [DW-1:0] rm  [WORDS];
  int qa[$], qk[$], qe[$], qo[$];

  // fault modes: 1 bit0 reads 1 at fa, 2 msb reads 0 at fa, 3 bit0 of fa cannot fall, 4 fa aliases to fb
  function automatic int phys(input int a);
    return (fmode == 4 && a == fa) ? fb : a;
  endfunction
  function automatic logic [DW-1:0] wval(input int p, input logic [DW-1:0] old, input logic [DW-1:0] d);
    if (fmode == 3 && p == fa) return {d[DW-1:1], d[0] | old[0]};
    return d;
  endfunction
  function automatic logic [DW-1:0] rval(input int p, input logic [DW-1:0] v);
    if (fmode == 1 && p == fa) return v | DW'(1);
    if (fmode == 2 && p == fa) return v & ~(DW'(1) << (DW - 1));
    return v;
  endfunction

  always @(posedge clk) begin
    if (mem_we) ram[phys(int'(mem_addr))] <= wval(phys(int'(mem_addr)), ram[phys(int'(mem_addr))], mem_wdata);
    if (mem_re) rdata <= rval(phys(int'(mem_addr)), ram[phys(int'(mem_addr))]);
  end

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // op codes: 0 r0, 1 r1, 2 w0, 3 w1
  task automatic add(input int e, input bit dn, input int o0, input int o1, input int o2);
    int ops[3];
    ops = '{o0, o1, o2};
    for (int s = 0; s < WORDS; s++) begin
      for (int j = 0; j < 3; j++) begin
        if (ops[j] >= 0) begin
          qa.push_back(dn ? WORDS - 1 - s : s); qk.push_back(ops[j]); qe.push_back(e); qo.push_back(j);
        end
      end
    end
  endtask

  task automatic build(input int alg);
    qa.delete(); qk.delete(); qe.delete(); qo.delete();
    add(0, 0, 2, -1, -1);
    add(1, 0, 0, 3, -1);
    if (alg == 0 || alg == 3) add(2, 1, 1, 2, -1);
    else if (alg == 1) add(2, 1, 1, 2, 0);
    else begin
      add(2, 0, 1, 2, -1); add(3, 1, 0, 3, -1); add(4, 1, 1, 2, -1); add(5, 0, 0, -1, -1);
    end
  endtask

  task automatic run(input int alg, input bit s, input int fm, input int xa, input int xb,
                     input int abort_at, input string tag);
    int n, ff, lst;
    bit stopped;
    fmode = fm; fa = xa; fb = xb;
    build(alg);
    n = qa.size();
    ff = -1;
    for (int i = 0; i < WORDS; i++) rm[i] = '0;
    for (int i = 0; i < n; i++) begin
      int p;
      logic [DW-1:0] v;
      p = phys(qa[i]);
      v = {DW{qk[i][0]}};
      if (qk[i] >= 2) rm[p] = wval(p, rm[p], v);
      else if (ff < 0 && rval(p, rm[p]) != v) ff = i;
    end
    @(negedge clk);
    if (abort_at < 0) for (int i = 0; i < WORDS; i++) ram[i] = '0;
    start = 1'b1; alg_sel = 2'(alg); stop_on_fail = s;
    @(negedge clk);
    start = 1'b0;
    stopped = s && ff >= 0 && ff < n - 1;
    lst = stopped ? ff + 1 : n - 1;
    for (int c = 0; c < 100000; c++) begin
      bit fe;
      fe = ff >= 0 && c >= ff + 2;
      if (abort_at >= 0 && c == abort_at) break;
      if (c <= lst) begin
        logic [DW-1:0] ew;
        ew = {DW{qk[c][0]}};
        chk(busy && !done && mem_we == (qk[c] >= 2) && mem_re == (qk[c] < 2) && int'(mem_addr) == qa[c]
            && (!mem_we || mem_wdata == ew), tag,
            $sformatf("c%0d b%0b d%0b we%0b re%0b a%0d w%h", c, busy, done, mem_we, mem_re, mem_addr, mem_wdata),
            $sformatf("c%0d b1 d0 we%0b re%0b a%0d w%h", c, qk[c] >= 2, qk[c] < 2, qa[c], ew));
      end else if (!stopped && c == n) begin
        chk(busy && !mem_we && !mem_re && !done, "R11",
            $sformatf("b%0b we%0b re%0b d%0b", busy, mem_we, mem_re, done), "b1 we0 re0 d0");
      end else begin
        chk(done && !busy, stopped ? "R10" : "R11", $sformatf("c%0d d%0b b%0b", c, done, busy),
            $sformatf("c%0d d1 b0", c));
        chk(fail == fe, "R8", $sformatf("%0b", fail), $sformatf("%0b", fe));
        if (ff >= 0)
          chk(int'(fail_addr) == qa[ff] && int'(fail_elem) == qe[ff] && int'(fail_op) == qo[ff], "R9",
              $sformatf("a%0d e%0d o%0d", fail_addr, fail_elem, fail_op),
              $sformatf("a%0d e%0d o%0d", qa[ff], qe[ff], qo[ff]));
        @(negedge clk);
        chk(!done && !busy && !mem_we && !mem_re, "R11", $sformatf("d%0b b%0b", done, busy), "d0 b0");
        break;
      end
      chk(fail == fe, "R8", $sformatf("c%0d %0b", c, fail), $sformatf("c%0d %0b", c, fe));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !mem_we && !mem_re, "R1",
        $sformatf("b%0b d%0b f%0b we%0b re%0b", busy, done, fail, mem_we, mem_re), "all 0");
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fail && !mem_we && !mem_re, "R1",
        $sformatf("b%0b d%0b f%0b we%0b re%0b", busy, done, fail, mem_we, mem_re), "all 0");
    run(0, 1'b0, 0, 0, 0, -1, "R4");
    run(1, 1'b0, 0, 0, 0, -1, "R5");
    run(2, 1'b0, 0, 0, 0, -1, "R6");
    run(3, 1'b0, 0, 0, 0, -1, "R4");
    run(0, 1'b0, 1, 5, 0, -1, "R3");
    run(2, 1'b1, 2, WORDS - 1, 0, -1, "R10");
    run(1, 1'b1, 3, 0, 0, -1, "R11");
    run(0, 1'b1, 4, 3, 7, -1, "R7");
    run(2, 1'b0, 4, 9, 2, -1, "R7");
    run(2, 1'b0, 1, 2, 0, 40, "R6");
    run(0, 1'b0, 0, 0, 0, -1, "R2");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule